// File: doc/BRIEF.md
# Power Domain Sequencer with Idle Handshake

This block switches a small set of power domains on and off under software control. Software writes a target state for each domain into a control register. The block then runs an ordered sequence for one domain at a time. To power a domain down, it first asks the domain's interconnect port to go idle. It waits until that port acknowledges and reports idle, and only then opens the power switch. To power a domain up, it closes the switch, waits until the domain reports ready, and then withdraws the idle request.

A settle counter holds the switch in its new state for a programmed number of cycles before the ready line is checked. Power-down and power-up use separate counts. A programmable timeout guards every wait. If a wait expires, the sequence stops, the block sets a sticky error bit for that domain and leaves the domain as it is.

Two parameters set what each domain has. A domain can have a power switch, an idle handshake, or both. For a domain without a switch, the on/off state is the state of its handshake. For a domain without a handshake, only the switch is sequenced.

Top module: `pds_ctrl`

## Requirements
- R1: The control register (byte offset 0x00) takes masked writes. Bit 16+i enables a write of bit i. A bit whose enable is 0 keeps its value. The register reads back the stored target bits in [N-1:0].
- R2: A control bit of 1 requests that domain off and 0 requests it on. The status register (0x08) bit i reads 1 when domain i is off and 0 when it is on. A switched domain's state comes from its ready input.
- R3: On power-down of a domain with a handshake, the block raises the idle request first. The power enable of that domain stays high until both the acknowledge and the idle status have been seen at 1.
- R4: On power-up of a domain with a handshake, the block raises the power enable first. The idle request is released only after the ready input has been seen at 1. The transition stays busy until both the acknowledge and the idle status return to 0.
- R5: The power-down settle count is at 0x10 and the power-up settle count is at 0x14, and both reset to 24. Each added count unit lengthens the wait between the switch change and the ready check by exactly one cycle.
- R6: For a domain with a handshake but no switch, the status bit equals its idle status input. Its sequence consists only of the handshake.
- R7: For a domain with a switch but no handshake, the idle request is never raised, and only the power enable is sequenced.
- R8: The timeout register (0x18) resets to 10000. A wait that does not complete within that many cycles ends the sequence and sets sticky error bit i of the state register (0x0C). The domain's outputs and status are left unchanged, and the domain is not retried. A control write that has enable bit 16+i set clears error bit i.
- R9: Only one transition runs at a time, and bit 31 of 0x0C reads 1 while one runs. When several domains are pending, the lowest index is served first.
- R10: A control write that asks for the state a domain already has starts no sequence and changes no idle request or power enable.
- R11: After reset, all control bits are 0, the switched domains' power enables are 1, all idle requests are 0, and the error bits and busy bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dom_idle_req | output | N | Idle request to each domain's interconnect port |
| dom_idle_ack | input | N | Acknowledge of the idle request |
| dom_idle_stat | input | N | Idle status of each port |
| dom_pwr_en | output | N | Power switch enable (1 = powered) |
| dom_pwr_rdy | input | N | Domain reports that power is good |

## Verification
On every cycle, the assertions check the ordering rules and the quiet-idle rule. A switch never opens before acknowledge and idle status were seen, and a request is never released before ready was seen. At most one domain output changes per edge. Nothing moves while the block is idle, error bits stay set until cleared, and switch-only domains never raise a request. The bench scenarios are needed for the rest: masked-write readback, the exact one-cycle-per-count settle timing, service order across several pending domains, the timeout ending in a held state, and the status encoding for each kind of domain.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_REQ    = 3'd1,
    S_SETTLE = 3'd2,
    S_CHK    = 3'd3,
    S_REL    = 3'd4
  } seq_st_t;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_STAT  = 8'h08;
  localparam logic [7:0] A_STATE = 8'h0C;
  localparam logic [7:0] A_DNCNT = 8'h10;
  localparam logic [7:0] A_UPCNT = 8'h14;
  localparam logic [7:0] A_TMO   = 8'h18;
endpackage

// File: rtl/pds_regs.sv
module pds_regs
  import pds_pkg::*;
#(
  parameter int N       = 4,
  parameter int CNT_W   = 16,
  parameter int TMO_W   = 16,
  parameter int CNT_RST = 24,
  parameter int TMO_RST = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [N-1:0]     tgt_off,
  output logic [N-1:0]     err_clr,
  output logic [CNT_W-1:0] dn_cnt,
  output logic [CNT_W-1:0] up_cnt,
  output logic [TMO_W-1:0] tmo,
  input  logic [N-1:0]     stat_off,
  input  logic [N-1:0]     err,
  input  logic             busy
);
  logic ctrl_wr;
  assign ctrl_wr = wr && (addr == A_CTRL);
  assign err_clr = ctrl_wr ? wdata[16 +: N] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_off <= '0;
      dn_cnt  <= CNT_W'(CNT_RST);
      up_cnt  <= CNT_W'(CNT_RST);
      tmo     <= TMO_W'(TMO_RST);
    end else if (wr) begin
      if (addr == A_CTRL) begin
        for (int i = 0; i < N; i++)
          if (wdata[16+i]) tgt_off[i] <= wdata[i];
      end
      if (addr == A_DNCNT) dn_cnt <= wdata[CNT_W-1:0];
      if (addr == A_UPCNT) up_cnt <= wdata[CNT_W-1:0];
      if (addr == A_TMO)   tmo    <= wdata[TMO_W-1:0];
    end
  end

  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    case (addr)
      A_CTRL:  rmux[N-1:0] = tgt_off;
      A_STAT:  rmux[N-1:0] = stat_off;
      A_STATE: begin
        rmux[N-1:0] = err;
        rmux[31]    = busy;
      end
      A_DNCNT: rmux[CNT_W-1:0] = dn_cnt;
      A_UPCNT: rmux[CNT_W-1:0] = up_cnt;
      A_TMO:   rmux[TMO_W-1:0] = tmo;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
  end
endmodule

// File: rtl/pds_pick.sv
module pds_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pds_seq.sv
module pds_seq
  import pds_pkg::*;
#(
  parameter int         N      = 4,
  parameter logic [N-1:0] HAS_SW = '1,
  parameter logic [N-1:0] HAS_HS = '1,
  parameter int         CNT_W  = 16,
  parameter int         TMO_W  = 16,
  parameter int         IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [CNT_W-1:0] dn_cnt,
  input  logic [CNT_W-1:0] up_cnt,
  input  logic [TMO_W-1:0] tmo,
  input  logic [N-1:0]     err_clr,
  input  logic [N-1:0]     idle_ack,
  input  logic [N-1:0]     idle_stat,
  input  logic [N-1:0]     pwr_rdy,
  output logic [N-1:0]     idle_req,
  output logic [N-1:0]     pwr_en,
  output logic [N-1:0]     cur_off,
  output logic [N-1:0]     err,
  output logic             busy
);
  seq_st_t          st;
  logic [IDX_W-1:0] idx;
  logic             goal_off;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmr;

  logic ack_s, idl_s, rdy_s, tmo_hit;
  assign ack_s   = idle_ack[idx];
  assign idl_s   = idle_stat[idx];
  assign rdy_s   = pwr_rdy[idx];
  assign tmo_hit = ({1'b0, tmr} + 1'b1) >= {1'b0, tmo};
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      goal_off <= 1'b0;
      cnt      <= '0;
      tmr      <= '0;
      idle_req <= '0;
      pwr_en   <= HAS_SW;
      cur_off  <= '0;
      err      <= '0;
    end else begin
      err <= err & ~err_clr;
      case (st)
        S_IDLE: begin
          if (start) begin
            idx      <= start_idx;
            goal_off <= ~cur_off[start_idx];
            tmr      <= '0;
            if (!cur_off[start_idx] && HAS_HS[start_idx]) begin
              idle_req[start_idx] <= 1'b1;
              st <= S_REQ;
            end else if (HAS_SW[start_idx]) begin
              pwr_en[start_idx] <= cur_off[start_idx];
              cnt <= cur_off[start_idx] ? up_cnt : dn_cnt;
              st  <= S_SETTLE;
            end else begin
              idle_req[start_idx] <= 1'b0;
              st <= S_REL;
            end
          end
        end
        S_REQ: begin
          if (ack_s && idl_s) begin
            if (HAS_SW[idx]) begin
              pwr_en[idx] <= 1'b0;
              cnt <= dn_cnt;
              st  <= S_SETTLE;
            end else begin
              cur_off[idx] <= 1'b1;
              st <= S_IDLE;
            end
          end else if (tmo_hit) begin
            err[idx] <= 1'b1;
            st <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_SETTLE: begin
          if (cnt == '0) begin
            tmr <= '0;
            st  <= S_CHK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CHK: begin
          if (rdy_s == !goal_off) begin
            if (!goal_off && HAS_HS[idx]) begin
              idle_req[idx] <= 1'b0;
              tmr <= '0;
              st  <= S_REL;
            end else begin
              cur_off[idx] <= goal_off;
              st <= S_IDLE;
            end
          end else if (tmo_hit) begin
            err[idx] <= 1'b1;
            st <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_REL: begin
          if (!ack_s && !idl_s) begin
            cur_off[idx] <= 1'b0;
            st <= S_IDLE;
          end else if (tmo_hit) begin
            err[idx] <= 1'b1;
            st <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl #(
  parameter int           N       = 4,
  parameter logic [N-1:0] HAS_SW  = 4'b0111,
  parameter logic [N-1:0] HAS_HS  = 4'b1011,
  parameter int           CNT_W   = 16,
  parameter int           TMO_W   = 16,
  parameter int           CNT_RST = 24,
  parameter int           TMO_RST = 10000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [7:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic [N-1:0] dom_idle_req,
  input  logic [N-1:0] dom_idle_ack,
  input  logic [N-1:0] dom_idle_stat,
  output logic [N-1:0] dom_pwr_en,
  input  logic [N-1:0] dom_pwr_rdy
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     tgt_off, err_clr, cur_off, seq_err, stat_off, pend;
  logic [CNT_W-1:0] dn_cnt, up_cnt;
  logic [TMO_W-1:0] tmo;
  logic             seq_busy, pend_any;
  logic [IDX_W-1:0] pend_idx;

  for (genvar g = 0; g < N; g++) begin : g_stat
    if (HAS_SW[g]) begin : g_sw
      assign stat_off[g] = ~dom_pwr_rdy[g];
    end else if (HAS_HS[g]) begin : g_hs
      assign stat_off[g] = dom_idle_stat[g];
    end else begin : g_none
      assign stat_off[g] = 1'b0;
    end
  end

  assign pend = (tgt_off ^ cur_off) & ~seq_err;

  pds_regs #(
    .N(N), .CNT_W(CNT_W), .TMO_W(TMO_W), .CNT_RST(CNT_RST), .TMO_RST(TMO_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .tgt_off(tgt_off), .err_clr(err_clr),
    .dn_cnt(dn_cnt), .up_cnt(up_cnt), .tmo(tmo), .stat_off(stat_off),
    .err(seq_err), .busy(seq_busy)
  );

  pds_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .any(pend_any), .idx(pend_idx)
  );

  pds_seq #(
    .N(N), .HAS_SW(HAS_SW), .HAS_HS(HAS_HS), .CNT_W(CNT_W), .TMO_W(TMO_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(pend_any), .start_idx(pend_idx),
    .dn_cnt(dn_cnt), .up_cnt(up_cnt), .tmo(tmo), .err_clr(err_clr),
    .idle_ack(dom_idle_ack), .idle_stat(dom_idle_stat), .pwr_rdy(dom_pwr_rdy),
    .idle_req(dom_idle_req), .pwr_en(dom_pwr_en), .cur_off(cur_off),
    .err(seq_err), .busy(seq_busy)
  );
endmodule

// File: rtl/pds_ctrl_chk.sv
module pds_ctrl_chk
  import pds_pkg::*;
#(
  parameter int           N      = 4,
  parameter logic [N-1:0] HAS_SW = '1,
  parameter logic [N-1:0] HAS_HS = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_wr,
  input logic [7:0]   bus_addr,
  input logic [31:0]  bus_wdata,
  input logic [N-1:0] idle_req,
  input logic [N-1:0] idle_ack,
  input logic [N-1:0] idle_stat,
  input logic [N-1:0] pwr_en,
  input logic [N-1:0] pwr_rdy,
  input logic [N-1:0] err,
  input logic         busy
);
  // R9: one output bit moves per edge at most
  a_r9_single_change: assert property (@(posedge clk) disable iff (rst)
    $countones((pwr_en ^ $past(pwr_en)) | (idle_req ^ $past(idle_req))) <= 1);

  // R10: with no transition running, outputs hold
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(pwr_en) && $stable(idle_req)));

  for (genvar g = 0; g < N; g++) begin : g_dom
    if (HAS_SW[g] && HAS_HS[g]) begin : g_both
      // R3: switch opens only after ack and idle were seen
      a_r3_down_gated: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en[g]) |-> $past(idle_ack[g] && idle_stat[g]));
      // R4: request released only while powered and after ready was seen
      a_r4_release_late: assert property (@(posedge clk) disable iff (rst)
        $fell(idle_req[g]) |-> (pwr_en[g] && $past(pwr_rdy[g])));
    end
    if (!HAS_HS[g]) begin : g_nohs
      // R7: a switch-only domain never sees a request
      a_r7_no_request: assert property (@(posedge clk) disable iff (rst)
        !idle_req[g]);
    end
    // R8: error bit stays set unless a control write enables its bit
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
      ($past(err[g]) && !($past(bus_wr) && ($past(bus_addr) == A_CTRL) && $past(bus_wdata[16+g])))
      |-> err[g]);
  end
endmodule

bind pds_ctrl pds_ctrl_chk #(.N(N), .HAS_SW(HAS_SW), .HAS_HS(HAS_HS)) u_pds_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .idle_req(dom_idle_req), .idle_ack(dom_idle_ack), .idle_stat(dom_idle_stat),
  .pwr_en(dom_pwr_en), .pwr_rdy(dom_pwr_rdy), .err(seq_err), .busy(seq_busy)
);

// File: tb/test_pds_ctrl.sv
module test_pds_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [N-1:0] SW = 4'b0111;
  localparam logic [N-1:0] HS = 4'b1011;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] idle_req, idle_ack, idle_stat, pwr_en, pwr_rdy;

  int n_chk = 0, n_bad = 0, n_chg = 0;
  logic fin = 1'b0;
  logic [N-1:0] stuck = '0, req_d1, en_d1, en_d2;
  logic [N-1:0] prev_req, prev_en;
  logic seen_req2;

  always #(CLK_PERIOD/2) clk = ~clk;

  pds_ctrl i_pds_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dom_idle_req(idle_req),
    .dom_idle_ack(idle_ack), .dom_idle_stat(idle_stat), .dom_pwr_en(pwr_en),
    .dom_pwr_rdy(pwr_rdy)
  );

  // domain responders: ack two edges after request, idle one after ack, ready three after enable
  always @(posedge clk) begin
    if (rst) begin
      req_d1 <= '0; idle_ack <= '0; idle_stat <= '0;
      en_d1 <= SW; en_d2 <= SW; pwr_rdy <= SW;
      prev_req <= '0; prev_en <= SW; seen_req2 <= 1'b0;
    end else begin
      req_d1 <= idle_req;
      for (int i = 0; i < N; i++) if (!stuck[i]) idle_ack[i] <= req_d1[i];
      idle_stat <= idle_ack;
      en_d1 <= pwr_en; en_d2 <= en_d1; pwr_rdy <= en_d2;
      if (idle_req !== prev_req || pwr_en !== prev_en) n_chg <= n_chg + 1;
      prev_req <= idle_req; prev_en <= pwr_en;
      if (idle_req[2]) seen_req2 <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(8'h0C, v);
      if (!v[31]) break;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R11 ctrl", v, 0);
    rd(8'h10, v); chk("R5 dn reset", v, 24);
    rd(8'h14, v); chk("R5 up reset", v, 24);
    rd(8'h18, v); chk("R8 tmo reset", v, 10000);
    rd(8'h0C, v); chk("R11 state", v, 0);
    rd(8'h08, v); chk("R2 status all on", v, 0);
    chk("R11 pwr_en", 32'(pwr_en), 32'(SW));
    chk("R11 idle_req", 32'(idle_req), 0);
  endtask

  task automatic t_mask_switch_only();
    logic [31:0] v;
    int c0;
    c0 = n_chg;
    wr(8'h00, 32'h0000_000F);
    cycles(20);
    rd(8'h00, v); chk("R1 no enable keeps", v, 0);
    chk("R1 no enable no motion", 32'(n_chg - c0), 0);
    wr(8'h00, 32'h0004_000F);
    rd(8'h00, v); chk("R1 only enabled bit", v, 32'h4);
    wait_idle();
    chk("R2 dom2 off enable", 32'(pwr_en), 32'b0011);
    rd(8'h08, v); chk("R2 dom2 status off", v, 32'h4);
    wr(8'h00, 32'h0004_0000);
    wait_idle();
    rd(8'h08, v); chk("R2 dom2 status on", v, 0);
    chk("R7 dom2 never requested", 32'(seen_req2), 0);
  endtask

  task automatic t_same_state();
    logic [31:0] v;
    int c0;
    c0 = n_chg;
    wr(8'h00, 32'h000F_0000);
    cycles(20);
    rd(8'h0C, v); chk("R10 not busy", v, 0);
    chk("R10 outputs untouched", 32'(n_chg - c0), 0);
  endtask

  task automatic t_down_order();
    logic [31:0] v;
    stuck[0] = 1'b1;
    wr(8'h00, 32'h0001_0001);
    cycles(30);
    chk("R3 request raised", 32'(idle_req[0]), 1);
    chk("R3 switch held without ack", 32'(pwr_en[0]), 1);
    stuck[0] = 1'b0;
    wait_idle();
    chk("R3 switch open after ack", 32'(pwr_en[0]), 0);
    rd(8'h08, v); chk("R3 dom0 status off", v, 32'h1);
  endtask

  task automatic t_up_order();
    logic [31:0] v;
    wr(8'h00, 32'h0001_0000);
    for (int k = 0; k < 300 && !pwr_en[0]; k++) @(negedge clk);
    chk("R4 enable rises while request held", 32'(idle_req[0]), 1);
    for (int k = 0; k < 300 && idle_req[0]; k++) @(negedge clk);
    chk("R4 release after ready", 32'(pwr_rdy[0]), 1);
    stuck[0] = 1'b1;
    cycles(20);
    rd(8'h0C, v); chk("R4 busy until ack drops", v, 32'h8000_0000);
    stuck[0] = 1'b0;
    wait_idle();
    rd(8'h08, v); chk("R4 dom0 on", v, 0);
  endtask

  task automatic t_hs_only();
    logic [31:0] v;
    wr(8'h00, 32'h0008_0008);
    wait_idle();
    rd(8'h08, v); chk("R6 dom3 off via idle", v, 32'h8);
    chk("R6 dom3 request held", 32'(idle_req[3]), 1);
    wr(8'h00, 32'h0008_0000);
    wait_idle();
    rd(8'h08, v); chk("R6 dom3 on", v, 0);
    chk("R6 dom3 request dropped", 32'(idle_req[3]), 0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(8'h00, 32'h0007_0007);
    rd(8'h0C, v); chk("R9 busy bit", v, 32'h8000_0000);
    for (int k = 0; k < 500 && pwr_en[0]; k++) @(negedge clk);
    chk("R9 dom0 first", 32'(pwr_en), 32'b0110);
    chk("R9 dom1 not yet requested", 32'(idle_req[1]), 0);
    for (int k = 0; k < 500 && pwr_en[1]; k++) @(negedge clk);
    chk("R9 dom1 before dom2", 32'(pwr_en), 32'b0100);
    wait_idle();
    rd(8'h08, v); chk("R9 all three off", v, 32'h7);
    wr(8'h00, 32'h0007_0000);
    wait_idle();
  endtask

  task automatic meas_up(input int cnt, output int n);
    wr(8'h00, 32'h0001_0001); wait_idle();
    wr(8'h14, 32'(cnt));
    wr(8'h00, 32'h0001_0000);
    for (int k = 0; k < 500 && !pwr_en[0]; k++) @(negedge clk);
    n = 0;
    for (int k = 0; k < 500 && idle_req[0]; k++) begin @(negedge clk); n++; end
    wait_idle();
  endtask

  task automatic meas_dn(input int cnt, output int n);
    wr(8'h10, 32'(cnt));
    wr(8'h00, 32'h0003_0003);
    for (int k = 0; k < 500 && pwr_en[0]; k++) @(negedge clk);
    n = 0;
    for (int k = 0; k < 500 && !idle_req[1]; k++) begin @(negedge clk); n++; end
    wait_idle();
    wr(8'h00, 32'h0003_0000); wait_idle();
  endtask

  task automatic t_settle();
    logic [31:0] v;
    int a, b;
    meas_up(5, a); meas_up(25, b);
    chk("R5 up count per cycle", 32'(b - a), 20);
    rd(8'h14, v); chk("R5 up readback", v, 25);
    meas_dn(4, a); meas_dn(14, b);
    chk("R5 down count per cycle", 32'(b - a), 10);
    rd(8'h10, v); chk("R5 down readback", v, 14);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int c0;
    wr(8'h18, 32'd40);
    rd(8'h18, v); chk("R8 tmo readback", v, 40);
    stuck[1] = 1'b1;
    wr(8'h00, 32'h0002_0002);
    cycles(120);
    rd(8'h0C, v); chk("R8 error set, idle", v, 32'h2);
    chk("R8 request held", 32'(idle_req[1]), 1);
    chk("R8 switch held", 32'(pwr_en[1]), 1);
    rd(8'h08, v); chk("R8 status unchanged", v, 0);
    c0 = n_chg;
    cycles(60);
    rd(8'h0C, v); chk("R8 error sticky", v, 32'h2);
    chk("R8 no retry", 32'(n_chg - c0), 0);
    stuck[1] = 1'b0;
    wr(8'h00, 32'h0002_0000);
    rd(8'h0C, v); chk("R8 error cleared", v, 0);
    wr(8'h00, 32'h0002_0002); wait_idle();
    rd(8'h08, v); chk("R8 recovered off", v, 32'h2);
    wr(8'h00, 32'h0002_0000); wait_idle();
    rd(8'h08, v); chk("R8 recovered on", v, 0);
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    cycles(5);
    rst = 1'b0;
    cycles(2);
    t_reset();
    t_mask_switch_only();
    t_same_state();
    t_down_order();
    t_up_order();
    t_hs_only();
    t_priority();
    t_settle();
    t_timeout();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule